// File: doc/BRIEF.md
# Picture-Tube Black-Level Calibration Sequencer

This block times the black-level calibration of a picture tube. It counts lines inside each vertical blanking interval and marks the last four lines of that interval as measuring lines. The first measuring line samples the cathode leakage current. Each of the next three lines enables the correction of one gun: red, then green, then blue. The length of the interval follows the field rate. A mode input can stretch the 60 Hz interval to the 50 Hz length, for example to cover a slow vertical flyback or to blank caption lines.

At switch-on the sequencer waits for the tube to warm up. The picture stays blanked and the beam-current-limit clamp stays engaged. The measuring lines still run, so that a drive level reaches the cathodes. When the digitized cathode current during a measuring line rises above a threshold code, stabilization starts. After a fixed number of slow timebase ticks, the blanking and the clamp are released.

A leakage sample outside the allowed window sets a sticky error flag. It also withholds the gun corrections for the rest of that field, so that the previous corrections are kept. The analog measurement, the gun drive and the white-point arithmetic are not part of this block.

Top module: `blk_cal_seq`

## Requirements
- R1: While reset is asserted, and directly after it, blank_out is 1, bcl_release is 0, adj_en is 000 and leak_err is 0. The sequencer is in the warm-up state.
- R2: The interval length L is latched at each vblank_start. L is BLANK_50 lines when field_60=0 or long_blank=1, and BLANK_60 lines otherwise. The line that begins at vblank_start is line 0, and each line_tick ends the current line. The measuring lines are lines L-4 to L-1.
- R3: meas_line is 1 during exactly the four measuring lines. This holds in every state, including warm-up.
- R4: leak_strobe is a one-cycle pulse. It coincides with the line_tick that ends the first measuring line, and that is the cycle in which meas_cur is taken as the leakage sample.
- R5: adj_en is one-hot or zero. Bit 0 (red) is high during the second measuring line, bit 1 (green) during the third and bit 2 (blue) during the fourth. This happens only while stabilization is active.
- R6: In warm-up, stabilization is inactive: adj_en stays 000, blank_out stays 1 and bcl_release stays 0. Warm-up ends at a line_tick during a measuring line at which the signed meas_cur is greater than WARM_CODE.
- R7: After warm-up ends, bcl_release rises on the clock edge that takes the RELEASE_TICKS-th time_tick pulse. From then on it stays 1, and blank_out is 1 only during the blanking interval.
- R8: While stabilization is active, a leakage sample above +LEAK_LIM or below -LEAK_LIM sets leak_err. leak_err then stays set until reset, and adj_en stays 000 for the rest of that field. A sample exactly at ±LEAK_LIM is accepted.
- R9: A vblank_start restarts line counting at line 0, even in the middle of an interval. On the next cycle meas_line is 0. It also lifts the per-field suppression of the gun corrections.
- R10: The line_tick that ends line L-1 closes the interval. After it, meas_line and adj_en are 0 and, once released, blank_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse at the end of each line |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| field_60 | input | 1 | 1 for a 60 Hz field, 0 for 50 Hz |
| long_blank | input | 1 | 1 gives 60 Hz fields the 50 Hz blanking length |
| time_tick | input | 1 | Slow timebase pulse for the release delay |
| meas_cur | input | CW | Signed digitized cathode current, 1 LSB per µA |
| blank_out | output | 1 | Picture blanking control |
| meas_line | output | 1 | High during the four measuring lines |
| leak_strobe | output | 1 | Leakage sample strobe |
| adj_en | output | 3 | Gun adjust enables: bit 0 red, bit 1 green, bit 2 blue |
| bcl_release | output | 1 | Releases the beam-current-limit clamp |
| leak_err | output | 1 | Sticky leakage-out-of-range flag |

## Verification
The hardest case to reach from the ports is a change of state inside a single field: warm-up ending on the red line, so that only green and blue are enabled in that field. The other is a field whose leakage sample fails after the release, combined with a following field that must recover. The stimulus drives each line's current separately, with one leakage value and one value for the remaining lines. This places the warm-up crossing on a chosen measuring line and puts the leakage at ±LEAK_LIM and just beyond it. A vblank_start issued in the middle of the green line covers the restart case.

// File: rtl/blk_cal_pkg.sv
package blk_cal_pkg;
  typedef enum logic [1:0] {
    ST_WARM   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } warm_st_e;
endpackage

// File: rtl/blk_line_timer.sv
module blk_line_timer #(
  parameter int BLANK_50 = 25,
  parameter int BLANK_60 = 21,
  parameter int LW       = $clog2(BLANK_50 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_tick,
  input  logic          vblank_start,
  input  logic          field_60,
  input  logic          long_blank,
  output logic          in_vb,
  output logic          meas_line,
  output logic [1:0]    phase
);
  logic          in_vb_q, in_vb_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] win_start;

  assign win_start = len_q - LW'(4);

  always_comb begin
    in_vb_d = in_vb_q;
    idx_d   = idx_q;
    len_d   = len_q;
    if (vblank_start) begin
      in_vb_d = 1'b1;
      idx_d   = '0;
      len_d   = (field_60 && !long_blank) ? LW'(BLANK_60) : LW'(BLANK_50);
    end else if (in_vb_q && line_tick) begin
      if (idx_q == len_q - LW'(1)) in_vb_d = 1'b0;
      else                         idx_d   = idx_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_vb_q <= 1'b0;
      idx_q   <= '0;
      len_q   <= LW'(BLANK_50);
    end else begin
      in_vb_q <= in_vb_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
    end
  end

  assign in_vb     = in_vb_q;
  assign meas_line = in_vb_q && (idx_q >= win_start);
  assign phase     = 2'(idx_q - win_start);
endmodule

// File: rtl/blk_warm_ctrl.sv
module blk_warm_ctrl
  import blk_cal_pkg::*;
#(
  parameter int CW            = 10,
  parameter int WARM_CODE     = 190,
  parameter int RELEASE_TICKS = 800,
  parameter int TW            = $clog2(RELEASE_TICKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_line,
  input  logic                 line_tick,
  input  logic                 time_tick,
  input  logic signed [CW-1:0] meas_cur,
  output logic                 stab_on,
  output logic                 released
);
  localparam logic signed [CW-1:0] WarmS = WARM_CODE[CW-1:0];

  warm_st_e      st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_WARM: begin
        if (meas_line && line_tick && (meas_cur > WarmS)) begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
      end
      ST_SETTLE: begin
        if (time_tick) begin
          if (cnt_q == TW'(RELEASE_TICKS - 1)) st_d  = ST_RUN;
          else                                 cnt_d = cnt_q + TW'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WARM;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign stab_on  = (st_q != ST_WARM);
  assign released = (st_q == ST_RUN);
endmodule

// File: rtl/blk_leak_mon.sv
module blk_leak_mon #(
  parameter int CW       = 10,
  parameter int LEAK_LIM = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vblank_start,
  input  logic                 leak_strobe,
  input  logic                 stab_on,
  input  logic signed [CW-1:0] meas_cur,
  output logic                 suppress,
  output logic                 leak_err
);
  localparam logic signed [CW-1:0] LimS = LEAK_LIM[CW-1:0];

  logic sup_q, sup_d, err_q, err_d, bad;

  assign bad = leak_strobe && stab_on && ((meas_cur > LimS) || (meas_cur < -LimS));

  always_comb begin
    sup_d = sup_q;
    err_d = err_q || bad;
    if (vblank_start) sup_d = 1'b0;
    else if (bad)     sup_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      sup_q <= sup_d;
      err_q <= err_d;
    end
  end

  assign suppress = sup_q;
  assign leak_err = err_q;
endmodule

// File: rtl/blk_cal_seq.sv
module blk_cal_seq #(
  parameter int CW            = 10,
  parameter int BLANK_50      = 25,
  parameter int BLANK_60      = 21,
  parameter int WARM_CODE     = 190,
  parameter int LEAK_LIM      = 100,
  parameter int RELEASE_TICKS = 800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_tick,
  input  logic                 vblank_start,
  input  logic                 field_60,
  input  logic                 long_blank,
  input  logic                 time_tick,
  input  logic signed [CW-1:0] meas_cur,
  output logic                 blank_out,
  output logic                 meas_line,
  output logic                 leak_strobe,
  output logic [2:0]           adj_en,
  output logic                 bcl_release,
  output logic                 leak_err
);
  logic       in_vb, stab_on, released, suppress;
  logic [1:0] phase;

  blk_line_timer #(.BLANK_50(BLANK_50), .BLANK_60(BLANK_60)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vblank_start(vblank_start),
    .field_60(field_60), .long_blank(long_blank),
    .in_vb(in_vb), .meas_line(meas_line), .phase(phase)
  );

  blk_warm_ctrl #(.CW(CW), .WARM_CODE(WARM_CODE), .RELEASE_TICKS(RELEASE_TICKS)) u_warm (
    .clk(clk), .rst_n(rst_n), .meas_line(meas_line), .line_tick(line_tick),
    .time_tick(time_tick), .meas_cur(meas_cur),
    .stab_on(stab_on), .released(released)
  );

  assign leak_strobe = meas_line && (phase == 2'd0) && line_tick;

  blk_leak_mon #(.CW(CW), .LEAK_LIM(LEAK_LIM)) u_leak (
    .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start), .leak_strobe(leak_strobe),
    .stab_on(stab_on), .meas_cur(meas_cur),
    .suppress(suppress), .leak_err(leak_err)
  );

  for (genvar g = 0; g < 3; g++) begin : g_gun
    assign adj_en[g] = stab_on && !suppress && meas_line && (phase == 2'(g + 1));
  end

  assign blank_out   = !released || in_vb;
  assign bcl_release = released;
endmodule

// File: rtl/blk_cal_seq_chk.sv
module blk_cal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_tick,
  input logic       vblank_start,
  input logic       blank_out,
  input logic       meas_line,
  input logic       leak_strobe,
  input logic [2:0] adj_en,
  input logic       bcl_release,
  input logic       leak_err
);
  AST_ADJ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adj_en)); // R5
  AST_ADJ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|adj_en) |-> (meas_line && !leak_strobe)); // R5
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    leak_strobe |-> (meas_line && line_tick)); // R4
  AST_HELD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !bcl_release |-> blank_out); // R6
  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bcl_release |=> bcl_release); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    leak_err |=> leak_err); // R8
  AST_VB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> !meas_line); // R9
endmodule

bind blk_cal_seq blk_cal_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vblank_start(vblank_start),
  .blank_out(blank_out), .meas_line(meas_line), .leak_strobe(leak_strobe),
  .adj_en(adj_en), .bcl_release(bcl_release), .leak_err(leak_err)
);

// File: tb/blk_cal_seq_tb_top.sv
`timescale 1ns/1ps
module blk_cal_seq_tb_top;
  localparam int CW = 10, B50 = 12, B60 = 9, WARM = 190, LIM = 100, RT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0, vblank_start = 1'b0, field_60 = 1'b0, long_blank = 1'b0, time_tick = 1'b0;
  logic signed [CW-1:0] meas_cur = '0;
  logic blank_out, meas_line, leak_strobe, bcl_release, leak_err;
  logic [2:0] adj_en;

  int cur_v = 0;
  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;
  bit tick_en = 1'b0;

  always #2 clk = ~clk;

  blk_cal_seq #(.CW(CW), .BLANK_50(B50), .BLANK_60(B60), .WARM_CODE(WARM),
                .LEAK_LIM(LIM), .RELEASE_TICKS(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vblank_start(vblank_start),
    .field_60(field_60), .long_blank(long_blank), .time_tick(time_tick), .meas_cur(meas_cur),
    .blank_out(blank_out), .meas_line(meas_line), .leak_strobe(leak_strobe),
    .adj_en(adj_en), .bcl_release(bcl_release), .leak_err(leak_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: interval, warm-up phase and per-field leakage status
  int m_invb, m_idx, m_len, m_st, m_cnt, m_bad, m_err;

  function automatic bit e_meas();
    return (m_invb != 0) && (m_idx >= m_len - 4);
  endfunction
  function automatic bit e_strobe();
    return e_meas() && (m_idx == m_len - 4) && line_tick;
  endfunction
  function automatic int e_adj();
    if (!e_meas() || m_st == 0 || m_bad != 0) return 0;
    case (m_idx - (m_len - 4))
      1: return 1;
      2: return 2;
      3: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_invb = 0; m_idx = 0; m_len = B50; m_st = 0; m_cnt = 0; m_bad = 0; m_err = 0;
    end else begin
      bit meas_o, strobe_o, bad_now;
      meas_o   = e_meas();
      strobe_o = e_strobe();
      bad_now  = strobe_o && (m_st != 0) && (cur_v > LIM || cur_v < -LIM);
      if (bad_now) m_err = 1;
      if (vblank_start) m_bad = 0; else if (bad_now) m_bad = 1;
      if (m_st == 0) begin
        if (meas_o && line_tick && cur_v > WARM) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1 && time_tick) begin
        if (m_cnt == RT - 1) m_st = 2; else m_cnt++;
      end
      if (vblank_start) begin
        m_invb = 1; m_idx = 0; m_len = (field_60 && !long_blank) ? B60 : B50;
      end else if (m_invb != 0 && line_tick) begin
        if (m_idx == m_len - 1) m_invb = 0; else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check(meas_line == e_meas(), "R3 meas_line", meas_line, e_meas());
      check(leak_strobe == e_strobe(), "R4 leak_strobe", leak_strobe, e_strobe());
      check(int'(adj_en) == e_adj(), "R5 adj_en", adj_en, e_adj());
      check(blank_out == (m_st != 2 || m_invb != 0), "R6/R7 blank_out", blank_out, (m_st != 2 || m_invb != 0));
      check(bcl_release == (m_st == 2), "R7 bcl_release", bcl_release, m_st == 2);
      check(leak_err == (m_err != 0), "R8 leak_err", leak_err, m_err);
    end
  end

  int first_meas, nstrobe;
  logic [2:0] adjm;

  task automatic set_cur(input int v);
    cur_v = v;
    meas_cur = v[CW-1:0];
  endtask

  task automatic run_field(input bit f60, input bit lb, input int nlines, input int leak_v, input int gun_v);
    int len;
    len = (f60 && !lb) ? B60 : B50;
    first_meas = -1; nstrobe = 0; adjm = '0;
    field_60 = f60; long_blank = lb;
    vblank_start = 1'b1;
    @(posedge clk); #1;
    vblank_start = 1'b0;
    for (int i = 0; i < nlines; i++) begin
      set_cur((i == len - 4) ? leak_v : gun_v);
      time_tick = tick_en;
      @(negedge clk);
      if (meas_line && first_meas < 0) first_meas = i;
      adjm |= adj_en;
      @(posedge clk); #1;
      time_tick = 1'b0;
      line_tick = 1'b1;
      @(negedge clk);
      if (leak_strobe) nstrobe++;
      @(posedge clk); #1;
      line_tick = 1'b0;
    end
  endtask

  initial begin
    #5;
    check(blank_out == 1'b1 && bcl_release == 1'b0 && adj_en == 3'b000 && leak_err == 1'b0,
          "R1 reset outputs", {blank_out, bcl_release, adj_en, leak_err}, 6'b100000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(blank_out == 1'b1 && meas_line == 1'b0, "R1 after reset", {blank_out, meas_line}, 2'b10);
    @(posedge clk); #1;

    run_field(1'b0, 1'b0, B50 + 2, 0, 50);
    check(first_meas == B50 - 4, "R2 50Hz window start", first_meas, B50 - 4);
    check(nstrobe == 1, "R4 one strobe", nstrobe, 1);
    check(adjm == 3'b000, "R6 no adjust in warm-up", adjm, 0);
    check(bcl_release == 1'b0 && blank_out == 1'b1, "R6 held blank", {bcl_release, blank_out}, 2'b01);

    run_field(1'b1, 1'b0, B60 + 2, 0, 50);
    check(first_meas == B60 - 4, "R2 60Hz window start", first_meas, B60 - 4);
    run_field(1'b1, 1'b1, B50 + 2, 0, 50);
    check(first_meas == B50 - 4, "R2 60Hz long window start", first_meas, B50 - 4);

    run_field(1'b0, 1'b0, B50 + 2, 0, WARM + 10);
    check(adjm == 3'b110, "R6 warm-up ends on red line", adjm, 6);
    check(bcl_release == 1'b0, "R7 not yet released", bcl_release, 0);

    tick_en = 1'b1;
    run_field(1'b0, 1'b0, B50 + 2, 20, 10);
    check(bcl_release == 1'b1, "R7 released", bcl_release, 1);
    check(blank_out == 1'b0 && meas_line == 1'b0, "R10 interval closed", {blank_out, meas_line}, 0);

    run_field(1'b1, 1'b0, B60 + 2, -LIM, 10);
    check(adjm == 3'b111, "R5 all guns", adjm, 7);
    check(leak_err == 1'b0, "R8 boundary accepted", leak_err, 0);

    run_field(1'b0, 1'b0, B50 + 2, LIM + 1, 10);
    check(adjm == 3'b000, "R8 corrections held", adjm, 0);
    check(leak_err == 1'b1, "R8 error set", leak_err, 1);

    run_field(1'b0, 1'b0, B50 + 2, 0, 10);
    check(adjm == 3'b111, "R9 suppression lifted", adjm, 7);
    check(leak_err == 1'b1, "R8 error sticky", leak_err, 1);

    run_field(1'b0, 1'b0, B50 - 2, 0, 10);
    run_field(1'b0, 1'b0, B50 + 2, 0, 10);
    check(first_meas == B50 - 4 && nstrobe == 1, "R9 restart mid-interval", first_meas, B50 - 4);
    check(adjm == 3'b111, "R9 full set after restart", adjm, 7);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule